// File: doc/BRIEF.md
# Memory Request Output Arbiter

This block sits between a four-context multithreaded processor and its node controller. It decides, each cycle, which pending memory request drives the one request port toward the controller. There are four kinds of candidate. One is a single retry register holding a request that the controller turned away. Another is a two-entry overflow queue per context. A third is the request leaving the shared second memory-pipeline stage, tagged with its context. The last is the dribble stream that carries register words out for fork and context-store work. The output is combinational from registered state plus the current inputs, so it is valid early in the cycle. The controller answers late in the same cycle on `req_accept`.

Context 0 always wins over the other contexts, so the context that services events can keep making progress. A high-water input holds back every request from contexts 1 to 3. The dribble stream normally sits at the bottom of the order. It moves up when the retry register holds a request from a context other than 0. A pipeline request that cannot go out at once is never lost. It is captured by the retry register if that register is free and the controller rejected it. Otherwise it is written into its context's overflow queue, so the shared pipeline always drains.

The retry register is a three-state machine: `FS_IDLE` (empty), `FS_CTX0` (holds a context-0 request) and `FS_OTHER` (holds a request from context 1 to 3). It moves from `FS_IDLE` to `FS_CTX0` or to `FS_OTHER` when the granted pipeline request is rejected. The choice depends on that request's context. It returns from either full state to `FS_IDLE` when its own request is granted and accepted. In every other case it holds its state and payload.

Top module: `req_out_arb`

## Requirements
- R1: After reset the retry register is `FS_IDLE`, all overflow queues are empty, the round-robin pointer selects context 1 first, and with no input requests `req_valid` is 0 and `grant` is all zeros.
- R2: Candidates are ranked highest first as follows. The retry register holding a context-0 request comes first. Next is the head of the context-0 queue, then the pipeline request of context 0. Below those are the retry register holding another context's request, then the queue heads of contexts 1 to 3, then a pipeline request of contexts 1 to 3.
- R3: The dribble stream has the lowest rank while the retry register is not in `FS_OTHER`. While it is in `FS_OTHER`, the dribble stream ranks just below the context-0 pipeline request and just above the retry register.
- R4: A granted pipeline request that is rejected while the retry register is `FS_IDLE` is loaded into it. The register then presents that same request, with the same context and data, until it is granted and accepted.
- R5: A valid pipeline request that is neither accepted nor loaded into the retry register is written into its own context's two-entry queue. A pipeline request is held out of direct arbitration when its context's queue is non-empty or when the retry register holds a request of its context. Queue entries leave in arrival order.
- R6: While `high_water` is 1, no request of contexts 1 to 3 is granted, whether from the retry register, a queue or the pipeline. Context-0 requests and the dribble stream are unaffected.
- R7: Among queue heads of contexts 1 to 3 that are eligible at once, a rotating pointer chooses. The pointer checks contexts in the order 1, 2, 3 and wraps, starting at its current value. After an accepted queue grant of context c it moves to the context after c.
- R8: `grant` is one-hot or zero. Bit 0 is the retry register, bit 1+c is the queue of context c, bit 5 is the pipeline, and bit 6 is the dribble stream. `req_valid` is 1 exactly when a bit is set, and `req_ctx`/`req_data` belong to that source. A source is consumed only on a cycle where `req_accept` is 1. A rejected queue head or dribble word is presented again later.
- R9: `ctx_block[c]` set to 1 means context c's request table cannot take an entry. It keeps that context's queue head and pipeline request out of arbitration. It does not affect the retry register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_valid | input | 1 | Second pipeline stage holds a memory request |
| pipe_ctx | input | 2 | Context of the pipeline request |
| pipe_data | input | 32 | Pipeline request payload |
| ctx_block | input | 4 | Per-context request table full or in conflict |
| high_water | input | 1 | Event queue high-water: hold back contexts 1 to 3 |
| drib_valid | input | 1 | Dribble stream has a word ready |
| drib_ctx | input | 2 | Context being dribbled |
| drib_data | input | 32 | Dribble word |
| req_accept | input | 1 | Controller took the presented request this cycle |
| req_valid | output | 1 | A request is presented |
| req_ctx | output | 2 | Context of the presented request |
| req_data | output | 32 | Payload of the presented request |
| grant | output | 7 | One-hot source of the presented request |

## Verification
The hardest situation to reach is the retry register in `FS_OTHER` while a context-0 request and a dribble word both compete. Only there does the dribble stream change rank. The stimulus reaches it by first having the controller reject a lone context-1 pipeline request. It then offers a dribble word, a second context-1 request and a context-0 request over the next cycles. Reaching two non-empty queues for the pointer to choose between needs a similar trick. A context's table is blocked while its pipeline request arrives, so the request is parked in the queue. The blocks are then released together.

// File: rtl/req_arb_pkg.sv
package req_arb_pkg;

    // State of the single retry register
    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_CTX0  = 2'd1,
        FS_OTHER = 2'd2
    } fail_state_e;

endpackage

// File: rtl/req_fifo2.sv
module req_fifo2 #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         not_empty,
    output logic [W-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + PW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            if (push && !pop)      count <= count + CW'(1);
            else if (pop && !push) count <= count - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    assign not_empty = (count != '0);
    assign head      = mem[rd_ptr];

    // R5: the pipeline must always find room to drain
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count != CW'(DEPTH)));

    // R8: a queue is only consumed when it holds something
    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int N = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 adv,
    output logic                 any,
    output logic [IW-1:0]        idx
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!any && req[j]) begin
                any = 1'b1;
                idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (adv && any) begin
            ptr <= (idx == IW'(N - 1)) ? '0 : idx + IW'(1);
        end
    end

    // R7: the pointer always names a real context
    p_ptr_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < N);

endmodule

// File: rtl/fail_slot.sv
module fail_slot
    import req_arb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CTX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CTX_W-1:0]  load_ctx,
    input  logic [DATA_W-1:0] load_data,
    input  logic              clear,
    output fail_state_e       state,
    output logic [CTX_W-1:0]  held_ctx,
    output logic [DATA_W-1:0] held_data
);
    fail_state_e       st;
    fail_state_e       st_nxt;
    logic [CTX_W-1:0]  ctx_q;
    logic [DATA_W-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= FS_IDLE;
            ctx_q  <= '0;
            data_q <= '0;
        end else begin
            st <= st_nxt;
            if (st == FS_IDLE && load) begin
                ctx_q  <= load_ctx;
                data_q <= load_data;
            end
        end
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            FS_IDLE: begin
                if (load) st_nxt = (load_ctx == '0) ? FS_CTX0 : FS_OTHER;
            end
            FS_CTX0, FS_OTHER: begin
                if (clear) st_nxt = FS_IDLE;
            end
            default: st_nxt = FS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        state     = st;
        held_ctx  = ctx_q;
        held_data = data_q;
    end

    // R4: a held request stays put until it is taken
    p_hold_until_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st != FS_IDLE && !clear) |=> (st == $past(st) && $stable(data_q) && $stable(ctx_q)));

endmodule

// File: rtl/req_out_arb.sv
module req_out_arb
    import req_arb_pkg::*;
#(
    parameter int NCTX   = 4,
    parameter int DATA_W = 32,
    parameter int QDEPTH = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pipe_valid,
    input  logic [$clog2(NCTX)-1:0] pipe_ctx,
    input  logic [DATA_W-1:0]      pipe_data,
    input  logic [NCTX-1:0]        ctx_block,
    input  logic                   high_water,
    input  logic                   drib_valid,
    input  logic [$clog2(NCTX)-1:0] drib_ctx,
    input  logic [DATA_W-1:0]      drib_data,
    input  logic                   req_accept,
    output logic                   req_valid,
    output logic [$clog2(NCTX)-1:0] req_ctx,
    output logic [DATA_W-1:0]      req_data,
    output logic [NCTX+2:0]        grant
);
    localparam int CTX_W  = $clog2(NCTX);
    localparam int SRC_W  = NCTX + 3;
    localparam int L_FAIL = 0;
    localparam int L_PIPE = NCTX + 1;
    localparam int L_DRIB = NCTX + 2;
    localparam int NRR    = NCTX - 1;
    localparam int RW     = (NRR > 1) ? $clog2(NRR) : 1;

    fail_state_e       fs;
    logic [CTX_W-1:0]  f_ctx;
    logic [DATA_W-1:0] f_data;

    logic [NCTX-1:0]   q_vld;
    logic [DATA_W-1:0] q_head [NCTX];
    logic [NCTX-1:0]   q_push;
    logic [NCTX-1:0]   q_pop;
    logic [NCTX-1:0]   q_ok;

    logic              pipe_ok;
    logic              pipe_gone;
    logic              rr_any;
    logic [RW-1:0]     rr_idx;
    logic              rr_adv;
    logic [SRC_W-1:0]  g;

    // eligibility of each source
    always_comb begin
        for (int c = 0; c < NCTX; c++) begin
            q_ok[c] = q_vld[c] && !ctx_block[c] && (c == 0 || !high_water);
        end
        pipe_ok = pipe_valid
                  && !ctx_block[pipe_ctx]
                  && !q_vld[pipe_ctx]
                  && !(fs != FS_IDLE && f_ctx == pipe_ctx)
                  && (pipe_ctx == '0 || !high_water);
    end

    rr_pick #(.N(NRR)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (q_ok[NCTX-1:1]),
        .adv   (rr_adv),
        .any   (rr_any),
        .idx   (rr_idx)
    );

    // fixed priority chain
    always_comb begin
        g = '0;
        if (fs == FS_CTX0)                          g[L_FAIL] = 1'b1;
        else if (q_ok[0])                           g[1] = 1'b1;
        else if (pipe_ok && pipe_ctx == '0)         g[L_PIPE] = 1'b1;
        else if (drib_valid && fs == FS_OTHER)      g[L_DRIB] = 1'b1;
        else if (fs == FS_OTHER && !high_water)     g[L_FAIL] = 1'b1;
        else if (rr_any)                            g[int'(rr_idx) + 2] = 1'b1;
        else if (pipe_ok)                           g[L_PIPE] = 1'b1;
        else if (drib_valid)                        g[L_DRIB] = 1'b1;
    end

    // output mux
    always_comb begin
        req_ctx  = '0;
        req_data = '0;
        if (g[L_FAIL]) begin
            req_ctx  = f_ctx;
            req_data = f_data;
        end
        for (int c = 0; c < NCTX; c++) begin
            if (g[c + 1]) begin
                req_ctx  = CTX_W'(c);
                req_data = q_head[c];
            end
        end
        if (g[L_PIPE]) begin
            req_ctx  = pipe_ctx;
            req_data = pipe_data;
        end
        if (g[L_DRIB]) begin
            req_ctx  = drib_ctx;
            req_data = drib_data;
        end
    end

    assign req_valid = |g;
    assign grant     = g;
    assign rr_adv    = req_accept && (|g[NCTX:2]);
    assign pipe_gone = g[L_PIPE] && (req_accept || fs == FS_IDLE);

    fail_slot #(.DATA_W(DATA_W), .CTX_W(CTX_W)) u_fail (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (g[L_PIPE] && !req_accept),
        .load_ctx  (pipe_ctx),
        .load_data (pipe_data),
        .clear     (g[L_FAIL] && req_accept),
        .state     (fs),
        .held_ctx  (f_ctx),
        .held_data (f_data)
    );

    generate
        for (genvar c = 0; c < NCTX; c++) begin : g_q
            assign q_push[c] = pipe_valid && (pipe_ctx == CTX_W'(c)) && !pipe_gone;
            assign q_pop[c]  = g[c + 1] && req_accept;
            req_fifo2 #(.W(DATA_W), .DEPTH(QDEPTH)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (q_push[c]),
                .push_data (pipe_data),
                .pop       (q_pop[c]),
                .not_empty (q_vld[c]),
                .head      (q_head[c])
            );
        end
    endgenerate

    // R2: a held context-0 retry is always what goes out
    p_ctx0_retry_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fs == FS_CTX0) |-> (req_valid && grant[L_FAIL] && req_ctx == '0));

    // R3: dribble outranks a held non-zero retry
    p_drib_over_retry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fs == FS_OTHER && drib_valid) |-> !grant[L_FAIL]);

    // R4: a rejected pipeline request lands in an empty retry register
    p_reject_captured_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[L_PIPE] && !req_accept && fs == FS_IDLE) |=> (fs != FS_IDLE && f_data == $past(pipe_data)));

    // R6: under high water only context 0 or dribble traffic leaves
    p_hw_ctx0_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (high_water && req_valid && !grant[L_DRIB]) |-> (req_ctx == '0));

    // R8: at most one source is granted
    p_onehot_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

// File: tb/tb_req_out_arb.sv
module tb_req_out_arb;

    typedef struct packed {
        logic        pv;
        logic [1:0]  pc;
        logic [31:0] pd;
        logic [3:0]  blk;
        logic        hw;
        logic        dv;
        logic [1:0]  dc;
        logic [31:0] dd;
        logic        acc;
        logic        ev;
        logic [6:0]  eg;
        logic [1:0]  ec;
        logic [31:0] ed;
        logic [3:0]  rq;
    } vec_t;

    // grant bits: 01 retry, 02 q0, 04 q1, 08 q2, 10 q3, 20 pipe, 40 dribble
    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{1,2,'hA1, 0,0, 0,0,0,    1, 1,'h20,2,'hA1, 8}, // R8 plain pipeline
        '{1,1,'hB1, 0,0, 0,0,0,    0, 1,'h20,1,'hB1, 4}, // R4 rejected -> retry
        '{1,1,'hB2, 0,0, 1,3,'hD1, 0, 1,'h40,3,'hD1, 3}, // R3 dribble above retry
        '{1,0,'hC1, 0,0, 1,3,'hD1, 1, 1,'h20,0,'hC1, 3}, // R3 ctx0 pipe above dribble
        '{0,0,0,    0,0, 1,3,'hD1, 1, 1,'h40,3,'hD1, 8}, // R8 rejected dribble repeats
        '{0,0,0,    0,0, 0,0,0,    1, 1,'h01,1,'hB1, 4}, // R4 retry goes out
        '{1,3,'hE1, 8,0, 0,0,0,    1, 1,'h04,1,'hB2, 5}, // R5 queued B2, R9 block ctx3
        '{1,2,'hF1, 4,0, 0,0,0,    1, 1,'h10,3,'hE1, 9}, // R9 blocked ctx2 parks
        '{0,0,0,    0,0, 0,0,0,    1, 1,'h08,2,'hF1, 7}, // R7
        '{1,1,'h61, 2,0, 0,0,0,    1, 0,0,0,0,       9}, // R9 nothing eligible
        '{1,3,'h71, 8,0, 0,0,0,    1, 1,'h04,1,'h61, 7}, // R7 pointer wraps to ctx1
        '{1,1,'h62, 2,0, 0,0,0,    0, 1,'h10,3,'h71, 7}, // R7 ctx3 after pointer 2
        '{0,0,0,    0,1, 0,0,0,    1, 0,0,0,0,       6}, // R6 queues 1,3 held back
        '{0,0,0,    0,0, 0,0,0,    1, 1,'h10,3,'h71, 8}, // R8 rejected head repeats
        '{0,0,0,    0,0, 0,0,0,    1, 1,'h04,1,'h62, 7}, // R7
        '{1,0,'h81, 1,0, 0,0,0,    1, 0,0,0,0,       9}, // R9 ctx0 blocked
        '{1,0,'h82, 0,0, 0,0,0,    0, 1,'h02,0,'h81, 5}, // R5 pipe waits behind queue
        '{0,0,0,    0,0, 0,0,0,    1, 1,'h02,0,'h81, 5}, // R5 order kept
        '{1,2,'h91, 0,0, 1,1,'hD2, 1, 1,'h02,0,'h82, 2}, // R2 q0 first
        '{0,0,0,    0,0, 1,1,'hD2, 1, 1,'h08,2,'h91, 3}, // R3 dribble lowest
        '{0,0,0,    0,0, 1,1,'hD2, 1, 1,'h40,1,'hD2, 3}, // R3
        '{1,0,'hC5, 0,0, 0,0,0,    0, 1,'h20,0,'hC5, 4}, // R4 ctx0 retry
        '{1,0,'hC6, 0,1, 0,0,0,    1, 1,'h01,0,'hC5, 2}, // R2 ctx0 retry top, R6
        '{0,0,0,    0,1, 0,0,0,    1, 1,'h02,0,'hC6, 6}, // R6 ctx0 queue passes
        '{1,1,'h55, 0,1, 0,0,0,    1, 0,0,0,0,       6}, // R6 ctx1 pipe held
        '{0,0,0,    0,0, 0,0,0,    1, 1,'h04,1,'h55, 6}, // R6
        '{1,3,'hE7, 0,0, 0,0,0,    0, 1,'h20,3,'hE7, 4}, // R4
        '{0,0,0,    0,1, 0,0,0,    1, 0,0,0,0,       6}, // R6 retry of ctx3 held
        '{0,0,0,    0,0, 0,0,0,    1, 1,'h01,3,'hE7, 4}, // R4
        '{0,0,0,    0,0, 0,0,0,    1, 0,0,0,0,       1}  // R1 back to empty
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pipe_valid;
    logic [1:0]  pipe_ctx;
    logic [31:0] pipe_data;
    logic [3:0]  ctx_block;
    logic        high_water;
    logic        drib_valid;
    logic [1:0]  drib_ctx;
    logic [31:0] drib_data;
    logic        req_accept;
    logic        req_valid;
    logic [1:0]  req_ctx;
    logic [31:0] req_data;
    logic [6:0]  grant;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    req_out_arb dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_valid (pipe_valid),
        .pipe_ctx   (pipe_ctx),
        .pipe_data  (pipe_data),
        .ctx_block  (ctx_block),
        .high_water (high_water),
        .drib_valid (drib_valid),
        .drib_ctx   (drib_ctx),
        .drib_data  (drib_data),
        .req_accept (req_accept),
        .req_valid  (req_valid),
        .req_ctx    (req_ctx),
        .req_data   (req_data),
        .grant      (grant)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle_inputs();
        pipe_valid = 0; pipe_ctx = 0; pipe_data = 0; ctx_block = 0;
        high_water = 0; drib_valid = 0; drib_ctx = 0; drib_data = 0;
        req_accept = 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_inputs();
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    // drive at the falling edge, sample 3 ns later, before the rising edge
    task automatic apply(input vec_t v);
        @(negedge clk);
        pipe_valid = v.pv; pipe_ctx = v.pc; pipe_data = v.pd; ctx_block = v.blk;
        high_water = v.hw; drib_valid = v.dv; drib_ctx = v.dc; drib_data = v.dd;
        req_accept = v.acc;
        #3;
    endtask

    task automatic expect_out(input string tag, input logic ev, input logic [6:0] eg,
                              input logic [1:0] ec, input logic [31:0] ed);
        check(req_valid == ev, {tag, " valid"}, 32'(req_valid), 32'(ev));
        check(grant == eg, {tag, " grant"}, 32'(grant), 32'(eg));
        if (ev) begin
            check(req_ctx == ec, {tag, " ctx"}, 32'(req_ctx), 32'(ec));
            check(req_data == ed, {tag, " data"}, req_data, ed);
        end
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        #3;
        expect_out("R1 reset", 0, 0, 0, 0);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            expect_out($sformatf("R%0d vec %0d", VEC[i].rq, i), VEC[i].ev, VEC[i].eg, VEC[i].ec, VEC[i].ed);
            check($countones(grant) <= 1, "R8 onehot", 32'(grant), 0);
        end

        // R1: reset empties a loaded retry register
        apply('{1,2,'h33, 0,0, 0,0,0, 0, 1,'h20,2,'h33, 1});
        expect_out("R1 preload", 1, 7'h20, 2, 32'h33);
        do_reset();
        #3;
        expect_out("R1 retry cleared", 0, 0, 0, 0);

        // R1/R7: pointer starts at context 1 after reset
        apply('{1,2,'h2A, 4'h4,0, 0,0,0, 1, 0,0,0,0, 7});
        expect_out("R7 park ctx2", 0, 0, 0, 0);
        apply('{1,1,'h1A, 4'h6,0, 0,0,0, 1, 0,0,0,0, 7});
        expect_out("R7 park ctx1", 0, 0, 0, 0);
        apply('{0,0,0, 0,0, 0,0,0, 1, 0,0,0,0, 7});
        expect_out("R7 first pick ctx1", 1, 7'h04, 1, 32'h1A);
        apply('{0,0,0, 0,0, 0,0,0, 1, 0,0,0,0, 7});
        expect_out("R7 then ctx2", 1, 7'h08, 2, 32'h2A);

        // R5: two queued entries of one context leave in order
        apply('{1,3,'h3A, 4'h8,0, 0,0,0, 1, 0,0,0,0, 5});
        apply('{1,3,'h3B, 4'h8,0, 0,0,0, 1, 0,0,0,0, 5});
        expect_out("R5 both parked", 0, 0, 0, 0);
        apply('{0,0,0, 0,0, 0,0,0, 1, 0,0,0,0, 5});
        expect_out("R5 first out", 1, 7'h10, 3, 32'h3A);
        apply('{0,0,0, 0,0, 0,0,0, 1, 0,0,0,0, 5});
        expect_out("R5 second out", 1, 7'h10, 3, 32'h3B);
        apply('{0,0,0, 0,0, 0,0,0, 1, 0,0,0,0, 5});
        expect_out("R5 drained", 0, 0, 0, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule